// File: doc/BRIEF.md
# Microwire PROM Reader with Host Pin Override

This block empties a serial PROM that speaks the three-wire Microwire protocol. One start pulse makes it walk the whole array, word by word, from address zero to the last address. For each word it raises chip select, clocks out a read command with the word address, skips the dummy bit and shifts in a 16-bit word. It then drops chip select for a recovery gap. Each finished word is presented on a parallel bus with its address and a one-cycle valid strobe. A final one-cycle done pulse closes the sweep.

While the sweep runs, `stream_en` stays high. Boards that load serial configuration registers straight from the PROM stream can use it as a shift enable, with the PROM clock pin as the shift clock and the PROM data line as the serial input. A host register can also take over the three PROM-facing outputs for software bit-banging, and it reads the synchronized PROM data line back.

The PROM serial clock is derived from the system clock. Each half-period lasts `HALF` system cycles. The address width, the word count and the data width are parameters.

Top module: `mw_prom_reader`

## Requirements
- R1: After reset, chip select, serial clock, data-to-PROM, `stream_en`, `word_valid` and `done` are all low. In automatic mode, chip select (active high) is high only while `stream_en` is high.
- R2: Each word transfer drives the following bits on `prom_di_o`, one bit per serial clock period: the header 1,1,0 (start bit, then the read opcode 10), then the `ADDR_W`-bit word address MSB first. `prom_di_o` is low in every other slot of the transfer.
- R3: In automatic mode, each serial clock half-period lasts exactly `HALF` system cycles. The serial clock is low whenever chip select is low. `prom_di_o` changes only together with a falling serial clock edge or a chip select edge.
- R4: After the address, one dummy bit is clocked and discarded. The next 16 bits, sampled at rising serial clock edges, form the word MSB first.
- R5: Words are read at addresses 0, 1, … `WORDS-1`, in that order. Each word appears on `word_data` with its address on `word_addr`, qualified by a `word_valid` pulse one cycle wide.
- R6: Between two consecutive word transfers, chip select stays low for at least `2*HALF` system cycles (one serial clock period).
- R7: After the last word, `done` pulses high for one cycle, and `stream_en` falls in that same cycle.
- R8: `stream_en` goes high in the cycle after an accepted start and stays high until `done`.
- R9: A start pulse has no effect while `host_en` is high or while a sweep is running. A running sweep keeps its address order.
- R10: A write with `host_wr` stores `host_wdata`. Bit 2 is chip select, bit 1 is the serial clock and bit 0 is data-to-PROM. While `host_en` is high, these bits appear on the pins two cycles after the write.
- R11: `host_rdata[0]` returns the level on `prom_do_i` within three cycles, through a two-stage synchronizer. `host_rdata[2:1]` return the stored chip select and clock bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a full-array read sweep |
| host_en | input | 1 | Hand the PROM pins to the host register |
| host_wr | input | 1 | Write strobe for the host register |
| host_wdata | input | 3 | Host register value: {cs, clock, data-to-PROM} |
| host_rdata | output | 3 | {stored cs, stored clock, synchronized PROM data} |
| prom_do_i | input | 1 | Serial data from the PROM |
| prom_cs_o | output | 1 | PROM chip select, active high |
| prom_clk_o | output | 1 | PROM serial clock |
| prom_di_o | output | 1 | Serial data to the PROM |
| stream_en | output | 1 | High for the whole automatic sweep |
| word_valid | output | 1 | One-cycle strobe for a completed word |
| word_addr | output | ADDR_W | Address of the presented word |
| word_data | output | DATA_W | Completed word |
| done | output | 1 | One-cycle pulse at the end of the sweep |

## Verification
The checks on pin behaviour assume that `host_en` only changes while no sweep is running. They also assume that the host register has been cleared to zero before `host_en` falls, so no host-driven chip select or data bit leaks onto the pins in the first automatic cycle. They further assume that `HALF` is at least 4, so a data bit that the PROM changes at a falling serial clock edge has passed the synchronizer before the next rising edge. The stimulus respects all three assumptions. It toggles host mode only between sweeps, always writes zero before leaving host mode, and applies random host values, random PROM contents and random idle gaps only inside those limits.

// File: rtl/mw_prom_pkg.sv
package mw_prom_pkg;

  // Word transfer phases: idle, low half of a bit slot, high half, and the
  // chip-select recovery gap after a word.
  typedef enum logic [1:0] {
    XF_IDLE,
    XF_LOW,
    XF_HIGH,
    XF_GAP
  } xfer_state_t;

  // Start bit followed by the two-bit read opcode, sent first in every frame.
  localparam logic [2:0] MW_READ_HDR = 3'b110;

  // Pin bit positions in the host register.
  localparam int HOST_CS_BIT  = 2;
  localparam int HOST_CLK_BIT = 1;
  localparam int HOST_DI_BIT  = 0;

endpackage

// File: rtl/mw_half_timer.sv
module mw_half_timer #(
  parameter int HALF = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);

  localparam int CW = (HALF > 2) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] TOP = CW'(HALF - 1);

  logic [CW-1:0] cnt_q;

  // The count restarts from zero whenever the timer is stopped, so every
  // phase after a restart lasts the full HALF cycles.
  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
    end else if (cnt_q == TOP) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick = run && (cnt_q == TOP);

endmodule

// File: rtl/mw_word_xfer.sv
module mw_word_xfer
  import mw_prom_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int HALF   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [ADDR_W-1:0] addr,
  input  logic              do_s,
  output logic              cs_o,
  output logic              sk_o,
  output logic              di_o,
  output logic              done_o,
  output logic              idle_o,
  output logic [DATA_W-1:0] data_o
);

  localparam int CMD_BITS  = 3 + ADDR_W;
  localparam int LAST_SLOT = CMD_BITS + DATA_W;
  localparam int SW        = $clog2(LAST_SLOT + 1);
  localparam logic [SW-1:0] CMD_END  = SW'(CMD_BITS);
  localparam logic [SW-1:0] CMD_LAST = SW'(CMD_BITS - 1);
  localparam logic [SW-1:0] SLOT_END = SW'(LAST_SLOT);

  xfer_state_t         st_q;
  logic [SW-1:0]       slot_q;
  logic [CMD_BITS-1:0] cmd_q;
  logic [DATA_W-1:0]   shreg_q;
  logic                gap_half_q;
  logic                tick;

  mw_half_timer #(.HALF(HALF)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .run  (st_q != XF_IDLE),
    .tick (tick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= XF_IDLE;
      slot_q     <= '0;
      cmd_q      <= '0;
      shreg_q    <= '0;
      gap_half_q <= 1'b0;
      cs_o       <= 1'b0;
      sk_o       <= 1'b0;
      di_o       <= 1'b0;
      done_o     <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (st_q)
        XF_IDLE: begin
          if (go) begin
            st_q   <= XF_LOW;
            slot_q <= '0;
            cs_o   <= 1'b1;
            sk_o   <= 1'b0;
            di_o   <= MW_READ_HDR[2];
            cmd_q  <= {MW_READ_HDR[1:0], addr, 1'b0};
          end
        end
        XF_LOW: begin
          if (tick) begin
            st_q <= XF_HIGH;
            sk_o <= 1'b1;
            // Rising edge: slots after the dummy slot carry data, MSB first.
            if (slot_q > CMD_END) begin
              shreg_q <= {shreg_q[DATA_W-2:0], do_s};
            end
          end
        end
        XF_HIGH: begin
          if (tick) begin
            sk_o <= 1'b0;
            if (slot_q == SLOT_END) begin
              st_q       <= XF_GAP;
              cs_o       <= 1'b0;
              di_o       <= 1'b0;
              done_o     <= 1'b1;
              gap_half_q <= 1'b0;
            end else begin
              // Falling edge: present the next command bit, or hold low.
              st_q   <= XF_LOW;
              slot_q <= slot_q + 1'b1;
              di_o   <= (slot_q < CMD_LAST) ? cmd_q[CMD_BITS-1] : 1'b0;
              cmd_q  <= cmd_q << 1;
            end
          end
        end
        XF_GAP: begin
          if (tick) begin
            gap_half_q <= 1'b1;
            if (gap_half_q) begin
              st_q <= XF_IDLE;
            end
          end
        end
        default: st_q <= XF_IDLE;
      endcase
    end
  end

  assign idle_o = (st_q == XF_IDLE);
  assign data_o = shreg_q;

endmodule

// File: rtl/mw_word_seq.sv
module mw_word_seq #(
  parameter int ADDR_W = 6,
  parameter int WORDS  = 64,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              host_en,
  input  logic              xfer_idle,
  input  logic              xfer_done,
  input  logic [DATA_W-1:0] xfer_data,
  output logic              go,
  output logic [ADDR_W-1:0] addr,
  output logic              busy,
  output logic              done,
  output logic              word_valid,
  output logic [ADDR_W-1:0] word_addr,
  output logic [DATA_W-1:0] word_data
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(WORDS - 1);

  logic last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      go         <= 1'b0;
      addr       <= '0;
      busy       <= 1'b0;
      done       <= 1'b0;
      last_q     <= 1'b0;
      word_valid <= 1'b0;
      word_addr  <= '0;
      word_data  <= '0;
    end else begin
      go         <= 1'b0;
      done       <= 1'b0;
      word_valid <= 1'b0;
      if (!busy) begin
        if (start && !host_en) begin
          busy   <= 1'b1;
          addr   <= '0;
          last_q <= 1'b0;
          go     <= 1'b1;
        end
      end else if (xfer_done) begin
        word_valid <= 1'b1;
        word_addr  <= addr;
        word_data  <= xfer_data;
        if (addr == LAST_ADDR) begin
          last_q <= 1'b1;
        end else begin
          addr <= addr + 1'b1;
        end
      end else if (xfer_idle && !go) begin
        // The transfer engine has finished its recovery gap.
        if (last_q) begin
          busy   <= 1'b0;
          done   <= 1'b1;
          last_q <= 1'b0;
        end else begin
          go <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/mw_pin_mux.sv
module mw_pin_mux
  import mw_prom_pkg::*;
#(
  parameter int SYNC = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       host_en,
  input  logic       host_wr,
  input  logic [2:0] host_wdata,
  input  logic       auto_cs,
  input  logic       auto_sk,
  input  logic       auto_di,
  input  logic       prom_do_i,
  output logic       prom_cs_o,
  output logic       prom_clk_o,
  output logic       prom_di_o,
  output logic       do_s,
  output logic [2:0] host_rdata
);

  logic [2:0]      host_q;
  logic [SYNC-1:0] sync_q;

  generate
    if (SYNC > 1) begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC-2:0], prom_do_i};
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= prom_do_i;
      end
    end
  endgenerate

  assign do_s = sync_q[SYNC-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      host_q     <= '0;
      prom_cs_o  <= 1'b0;
      prom_clk_o <= 1'b0;
      prom_di_o  <= 1'b0;
      host_rdata <= '0;
    end else begin
      if (host_wr) begin
        host_q <= host_wdata;
      end
      if (host_en) begin
        prom_cs_o  <= host_q[HOST_CS_BIT];
        prom_clk_o <= host_q[HOST_CLK_BIT];
        prom_di_o  <= host_q[HOST_DI_BIT];
      end else begin
        prom_cs_o  <= auto_cs;
        prom_clk_o <= auto_sk;
        prom_di_o  <= auto_di;
      end
      host_rdata <= {host_q[HOST_CS_BIT], host_q[HOST_CLK_BIT], do_s};
    end
  end

endmodule

// File: rtl/mw_prom_reader.sv
module mw_prom_reader #(
  parameter int ADDR_W = 6,
  parameter int WORDS  = 64,
  parameter int DATA_W = 16,
  parameter int HALF   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              host_en,
  input  logic              host_wr,
  input  logic [2:0]        host_wdata,
  output logic [2:0]        host_rdata,
  input  logic              prom_do_i,
  output logic              prom_cs_o,
  output logic              prom_clk_o,
  output logic              prom_di_o,
  output logic              stream_en,
  output logic              word_valid,
  output logic [ADDR_W-1:0] word_addr,
  output logic [DATA_W-1:0] word_data,
  output logic              done
);

  logic              go;
  logic [ADDR_W-1:0] cur_addr;
  logic              xf_cs, xf_sk, xf_di, xf_done, xf_idle;
  logic [DATA_W-1:0] xf_data;
  logic              do_s;

  mw_word_seq #(
    .ADDR_W (ADDR_W),
    .WORDS  (WORDS),
    .DATA_W (DATA_W)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .host_en    (host_en),
    .xfer_idle  (xf_idle),
    .xfer_done  (xf_done),
    .xfer_data  (xf_data),
    .go         (go),
    .addr       (cur_addr),
    .busy       (stream_en),
    .done       (done),
    .word_valid (word_valid),
    .word_addr  (word_addr),
    .word_data  (word_data)
  );

  mw_word_xfer #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .HALF   (HALF)
  ) u_xfer (
    .clk    (clk),
    .rst    (rst),
    .go     (go),
    .addr   (cur_addr),
    .do_s   (do_s),
    .cs_o   (xf_cs),
    .sk_o   (xf_sk),
    .di_o   (xf_di),
    .done_o (xf_done),
    .idle_o (xf_idle),
    .data_o (xf_data)
  );

  mw_pin_mux #(.SYNC(2)) u_pins (
    .clk        (clk),
    .rst        (rst),
    .host_en    (host_en),
    .host_wr    (host_wr),
    .host_wdata (host_wdata),
    .auto_cs    (xf_cs),
    .auto_sk    (xf_sk),
    .auto_di    (xf_di),
    .prom_do_i  (prom_do_i),
    .prom_cs_o  (prom_cs_o),
    .prom_clk_o (prom_clk_o),
    .prom_di_o  (prom_di_o),
    .do_s       (do_s),
    .host_rdata (host_rdata)
  );

endmodule

// File: rtl/mw_prom_reader_chk.sv
module mw_prom_reader_chk #(
  parameter int ADDR_W = 6,
  parameter int HALF   = 4
) (
  input logic       clk,
  input logic       rst,
  input logic       host_en,
  input logic       host_wr,
  input logic [2:0] host_wdata,
  input logic       prom_cs_o,
  input logic       prom_clk_o,
  input logic       prom_di_o,
  input logic       stream_en,
  input logic       word_valid,
  input logic       done
);

  localparam int CMD_BITS = 3 + ADDR_W;
  localparam int GAP_MIN  = 2 * HALF;
  localparam int LW       = $clog2(GAP_MIN + 1);

  logic [LW-1:0] low_cnt;
  logic [7:0]    rise_cnt;
  logic          clk_prev, cs_prev, had_word;
  logic          rise_now;
  logic [8:0]    rises_incl;

  assign rise_now   = prom_clk_o && !clk_prev;
  assign rises_incl = {1'b0, rise_cnt} + {8'd0, rise_now};

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt  <= '0;
      rise_cnt <= '0;
      clk_prev <= 1'b0;
      cs_prev  <= 1'b0;
      had_word <= 1'b0;
    end else begin
      clk_prev <= prom_clk_o;
      cs_prev  <= prom_cs_o;
      if (prom_cs_o)                      low_cnt <= '0;
      else if (low_cnt != LW'(GAP_MIN))   low_cnt <= low_cnt + 1'b1;
      if (!prom_cs_o)                     rise_cnt <= '0;
      else if (rise_now && rise_cnt != 8'hFF) rise_cnt <= rise_cnt + 1'b1;
      if (!stream_en)      had_word <= 1'b0;
      else if (word_valid) had_word <= 1'b1;
    end
  end

  p_cs_in_sweep_r1: assert property (@(posedge clk) disable iff (rst)
    (!host_en && prom_cs_o) |-> stream_en);

  p_di_cmd_only_r2: assert property (@(posedge clk) disable iff (rst)
    (!host_en && prom_di_o) |-> (prom_cs_o && rises_incl <= 9'(CMD_BITS)));

  p_clk_low_idle_r3: assert property (@(posedge clk) disable iff (rst)
    (!host_en && !prom_cs_o) |-> !prom_clk_o);

  p_valid_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    word_valid |=> !word_valid);

  p_word_gap_r6: assert property (@(posedge clk) disable iff (rst)
    (!host_en && prom_cs_o && !cs_prev && had_word) |-> (low_cnt == LW'(GAP_MIN)));

  p_done_ends_sweep_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> (!stream_en && $past(stream_en)));

  p_host_pins_r10: assert property (@(posedge clk) disable iff (rst)
    (host_en && $past(host_en) && $past(host_en, 2) && $past(host_wr, 2))
      |-> ({prom_cs_o, prom_clk_o, prom_di_o} == $past(host_wdata, 2)));

endmodule

bind mw_prom_reader mw_prom_reader_chk #(
  .ADDR_W (ADDR_W),
  .HALF   (HALF)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .host_en    (host_en),
  .host_wr    (host_wr),
  .host_wdata (host_wdata),
  .prom_cs_o  (prom_cs_o),
  .prom_clk_o (prom_clk_o),
  .prom_di_o  (prom_di_o),
  .stream_en  (stream_en),
  .word_valid (word_valid),
  .done       (done)
);

// File: tb/mw_prom_reader_test.sv
module mw_prom_reader_test;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 4;
  localparam int WORDS      = 12;
  localparam int DATA_W     = 16;
  localparam int HALF       = 4;
  localparam int CMD_BITS   = 3 + ADDR_W;
  localparam int WATCHDOG   = 150000;

  logic              clk = 1'b0;
  logic              rst, start, host_en, host_wr;
  logic [2:0]        host_wdata, host_rdata;
  logic              prom_do_i, prom_cs_o, prom_clk_o, prom_di_o;
  logic              stream_en, word_valid, done;
  logic [ADDR_W-1:0] word_addr;
  logic [DATA_W-1:0] word_data;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mw_prom_reader #(
    .ADDR_W (ADDR_W), .WORDS (WORDS), .DATA_W (DATA_W), .HALF (HALF)
  ) uut (
    .clk (clk), .rst (rst), .start (start), .host_en (host_en),
    .host_wr (host_wr), .host_wdata (host_wdata), .host_rdata (host_rdata),
    .prom_do_i (prom_do_i), .prom_cs_o (prom_cs_o), .prom_clk_o (prom_clk_o),
    .prom_di_o (prom_di_o), .stream_en (stream_en), .word_valid (word_valid),
    .word_addr (word_addr), .word_data (word_data), .done (done)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  logic [15:0] base = 16'h0;

  function automatic logic [15:0] mem_word(input int a, input logic [15:0] b);
    return 16'(a * 40503) ^ b ^ {4'(a), 12'h0A5};
  endfunction

  // PROM model and pin monitors, all sampled away from the active edge.
  logic                tb_do_sel = 1'b0, tb_do = 1'b0, m_do = 1'b0;
  logic [CMD_BITS-1:0] m_rx = '0;
  logic [16:0]         m_sr = '0;
  int                  m_cnt = 0, n_frames = 0, hdr_bad = 0, addr_bad = 0;
  logic                prev_sk = 1'b0, prev_cs = 1'b0, prev_di = 1'b0;
  int                  r1_bad = 0, r2_bad = 0, r3_bad = 0, r6_bad = 0;
  int                  low_len = 0, high_len = 0, run_words = 0;

  assign prom_do_i = tb_do_sel ? tb_do : m_do;

  always @(negedge clk) begin
    if (!rst && !host_en) begin
      if (prom_cs_o && !stream_en) r1_bad++;
      if (prom_di_o && !prom_cs_o) r2_bad++;
      if (prom_di_o && m_cnt > CMD_BITS) r2_bad++;
      if (prom_clk_o && !prom_cs_o) r3_bad++;
      if (prom_di_o != prev_di && !(prev_sk && !prom_clk_o) && prom_cs_o == prev_cs) r3_bad++;
      if (prom_clk_o) high_len++;
      if (!prom_clk_o && prev_sk) begin
        if (high_len != HALF) r3_bad++;
        high_len = 0;
      end
      if (prom_cs_o && !prev_cs && run_words > 0 && low_len < 2 * HALF) r6_bad++;
      if (!prom_cs_o) low_len++; else low_len = 0;
    end
    if (!prom_cs_o || host_en) begin
      m_cnt = 0;
      m_do  = 1'b0;
    end else if (prom_clk_o && !prev_sk && m_cnt < CMD_BITS) begin
      m_rx = {m_rx[CMD_BITS-2:0], prom_di_o};
      m_cnt++;
    end else if (!prom_clk_o && prev_sk && m_cnt == CMD_BITS) begin
      if (m_rx[CMD_BITS-1 -: 3] != 3'b110) hdr_bad++;
      if (int'(m_rx[ADDR_W-1:0]) != n_frames % WORDS) addr_bad++;
      n_frames++;
      m_sr  = {1'b0, mem_word(int'(m_rx[ADDR_W-1:0]), base)};
      m_do  = m_sr[16];
      m_cnt = CMD_BITS + 1;
    end else if (!prom_clk_o && prev_sk && m_cnt > CMD_BITS) begin
      m_sr = m_sr << 1;
      m_do = m_sr[16];
    end
    prev_sk = prom_clk_o;
    prev_cs = prom_cs_o;
    prev_di = prom_di_o;
  end

  // Word collector: order, address and data of each strobe (R4, R5).
  int exp_addr = 0, n_words = 0, n_done = 0;
  always @(negedge clk) begin
    if (!rst && word_valid) begin
      chk(int'(word_addr) == exp_addr, "R5", "word address", word_addr, exp_addr);
      chk(word_data == mem_word(int'(word_addr), base), "R4", "word data",
          word_data, mem_word(int'(word_addr), base));
      exp_addr++;
      n_words++;
      run_words++;
    end
    if (!rst && done) n_done++;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_start();
    start = 1'b1;
    tick(1);
    start = 1'b0;
  endtask

  task automatic host_write(input logic [2:0] v);
    host_wdata = v;
    host_wr    = 1'b1;
    tick(1);
    host_wr    = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    int r8_bad = 0;
    while (!done && n < 20000) begin
      if (!stream_en) r8_bad++;
      tick(1);
      n++;
    end
    chk(done == 1'b1, "R7", {tag, " done pulse"}, done, 1);
    chk(stream_en == 1'b0, "R7", {tag, " stream_en low with done"}, stream_en, 0);
    chk(r8_bad == 0, "R8", {tag, " stream_en dropped early"}, r8_bad, 0);
    tick(1);
    chk(done == 1'b0, "R7", {tag, " done one cycle"}, done, 0);
  endtask

  task automatic run_sweep(input string tag, input bit poke_start);
    base      = 16'($urandom);
    exp_addr  = 0;
    n_words   = 0;
    n_done    = 0;
    run_words = 0;
    n_frames  = 0;
    tick(1 + ($urandom % 7));
    pulse_start();
    chk(stream_en == 1'b1, "R8", {tag, " stream_en after start"}, stream_en, 1);
    if (poke_start) begin
      while (n_words < 3) tick(1);
      pulse_start();  // R9: ignored while the sweep runs
    end
    wait_done(tag);
    chk(n_words == WORDS, "R5", {tag, " word count"}, n_words, WORDS);
    chk(n_done == 1, "R7", {tag, " done count"}, n_done, 1);
    chk(hdr_bad == 0, "R2", {tag, " frame header"}, hdr_bad, 0);
    chk(addr_bad == 0, "R2", {tag, " frame address"}, addr_bad, 0);
    chk(n_frames == WORDS, "R9", {tag, " frames sent"}, n_frames, WORDS);
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    rst = 1'b1; start = 1'b0; host_en = 1'b0; host_wr = 1'b0; host_wdata = '0;
    tick(4);
    rst = 1'b0;
    tick(1);
    // R1: reset state
    chk({prom_cs_o, prom_clk_o, prom_di_o} == 3'b000, "R1", "pins after reset",
        {prom_cs_o, prom_clk_o, prom_di_o}, 0);
    chk({stream_en, word_valid, done} == 3'b000, "R1", "status after reset",
        {stream_en, word_valid, done}, 0);

    run_sweep("sweep A", 1'b0);
    run_sweep("sweep B", 1'b1);

    // R9: start ignored in host mode
    host_en = 1'b1;
    tick(2);
    n_words = 0;
    pulse_start();
    tick(60);
    chk(stream_en == 1'b0, "R9", "start in host mode", stream_en, 0);
    chk(n_words == 0, "R9", "no words in host mode", n_words, 0);

    // R10: random host pin values
    for (int i = 0; i < 10; i++) begin
      logic [2:0] v;
      v = 3'($urandom);
      if (i == 0) v = 3'b111;
      host_write(v);
      tick(1);
      chk({prom_cs_o, prom_clk_o, prom_di_o} == v, "R10", "host pins",
          {prom_cs_o, prom_clk_o, prom_di_o}, v);
      chk(host_rdata[2:1] == v[2:1], "R11", "host readback cs/clk", host_rdata[2:1], v[2:1]);
    end

    // R11: data-line readback
    tb_do_sel = 1'b1;
    for (int i = 0; i < 8; i++) begin
      logic b;
      b = (i < 2) ? 1'(i) : 1'($urandom);
      tb_do = b;
      tick(3);
      chk(host_rdata[0] == b, "R11", "data line readback", host_rdata[0], b);
    end
    tb_do_sel = 1'b0;

    host_write(3'b000);
    tick(2);
    host_en = 1'b0;
    tick(3);
    chk(stream_en == 1'b0, "R9", "no sweep after host mode", stream_en, 0);

    run_sweep("sweep C", 1'b0);

    chk(r1_bad == 0, "R1", "cs outside sweep", r1_bad, 0);
    chk(r2_bad == 0, "R2", "data-to-PROM outside command", r2_bad, 0);
    chk(r3_bad == 0, "R3", "serial clock timing", r3_bad, 0);
    chk(r6_bad == 0, "R6", "chip-select gap", r6_bad, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R7 watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule